// File: doc/BRIEF.md
# Fault-Map Guided Memory Request Router

This block sits on the path from the last-level-cache miss queue to the memory controller. Each incoming line request carries a line address, a read/write flag and the line's replication bit. For reads, the block looks up the 4-bit fault-map entry of the line in a small on-chip fault-map cache. It then issues either a single main-memory read, or a main-memory read plus a replication-area read for the replicated word. Writes are steered by the replication bit alone. They go to main memory, and to the replication area as well when the bit is set.

Fault-map entries live in memory, 128 of them packed into one 512-bit fault-map line. When a read finds its fault-map line absent from the cache, the router first issues a fault-map line fetch. It installs the returned line in the cache and only then routes the original read using the fresh entry. One request is handled at a time. A busy flag refuses new requests until every transaction issued for the current one has reported completion.

Top module: `fmap_router`

## Requirements
- R1: After reset, busy is low and none of mm_valid, ra_valid or fm_valid is high.
- R2: The fault-map line of a data line is its address shifted right by 7 (fm_line), and the entry slot is the low 7 address bits. The entry for slot s is fm_data bits [4s+3:4s].
- R3: A read whose entry is cached and equals zero issues exactly one main-memory read (mm_valid with mm_write=0, mm_line = request line), with no replication-area or fault-map request.
- R4: A read whose cached entry is nonzero issues a main-memory read and, in the same cycle, a replication-area read with ra_line = request line and ra_word = entry bits [2:0].
- R5: A read whose fault-map line is not cached first issues one fault-map fetch (fm_valid, fm_line). It issues no memory or replication request until fm_done. After fm_done it routes the read by the entry taken from fm_data, as in R3 and R4.
- R6: A write with req_rbit=1 issues a main-memory write and, in the same cycle, a replication-area write with ra_word=0. It never issues a fault-map fetch, whether or not its fault-map line is cached.
- R7: A write with req_rbit=0 issues only a main-memory write.
- R8: A request is accepted when req_valid is high and busy is low. busy is high from the cycle after acceptance until the cycle after the last outstanding mm_done/ra_done/fm_done. req_valid while busy is ignored and issues nothing.
- R9: The fault-map cache is direct-mapped with 8 lines, indexed by fm_line bits [2:0]. A fetched line stays cached until a fetch of another fault-map line with the same index replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Line request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rbit | input | 1 | Replication bit of the line (used by writes) |
| req_line | input | LINE_AW | Data line address |
| busy | output | 1 | Request in progress, new requests refused |
| mm_valid | output | 1 | One-cycle main-memory request pulse |
| mm_write | output | 1 | Main-memory request is a write |
| mm_line | output | LINE_AW | Main-memory line address |
| mm_done | input | 1 | Main-memory request completed |
| ra_valid | output | 1 | One-cycle replication-area request pulse |
| ra_write | output | 1 | Replication-area request is a write |
| ra_line | output | LINE_AW | Line whose replicated word is addressed |
| ra_word | output | 3 | Faulty word index within the line |
| ra_done | input | 1 | Replication-area request completed |
| fm_valid | output | 1 | One-cycle fault-map line fetch pulse |
| fm_line | output | LINE_AW-7 | Fault-map line address |
| fm_done | input | 1 | Fault-map fetch completed, fm_data valid |
| fm_data | input | 512 | Returned fault-map line, 128 entries of 4 bits |

## Verification
The routing is driven with reads that miss the cache, reads that hit a zero entry and reads that hit a nonzero entry. These separate the single-read path, the dual-read path and the fetch-then-route path. Entries sit at the first and last slots of a fault-map line, which shows whether the slot-to-bit mapping is right. Writes are sent with the replication bit both set and clear, to uncached fault-map lines as well, so dual-location writes can be told from plain ones and any needless fetch is caught. Fault-map lines sharing a cache index, a sweep over scattered addresses, and requests held during busy show whether eviction, hit tracking and the one-at-a-time rule behave.

// File: rtl/fmr_pkg.sv
// Package: shared constants and the controller state type for the
// fault-map request router. Assumes 4-bit entries and 8 words per line.
package fmr_pkg;
    localparam int ENTRY_W   = 4;    // bits per fault-map entry
    localparam int LINE_WORDS = 8;   // 8-byte words in a 64-byte line
    localparam int WORD_W    = $clog2(LINE_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2,
        ST_WAIT = 2'd3
    } rt_state_e;
endpackage

// File: rtl/fmr_addr_split.sv
// Address splitter: derives the fault-map line, the slot within it, and the
// cache index and tag from a data line address. Pure combinational.
// Assumes ENTRIES and CACHE_LINES are powers of two.
module fmr_addr_split #(
    parameter int LINE_AW     = 20,
    parameter int ENTRIES     = 128,
    parameter int CACHE_LINES = 8,
    localparam int SLOT_W = $clog2(ENTRIES),
    localparam int FM_AW  = LINE_AW - SLOT_W,
    localparam int IDX_W  = $clog2(CACHE_LINES),
    localparam int TAG_W  = FM_AW - IDX_W
) (
    input  logic [LINE_AW-1:0] line,
    output logic [FM_AW-1:0]   fm_line,
    output logic [SLOT_W-1:0]  slot,
    output logic [IDX_W-1:0]   idx,
    output logic [TAG_W-1:0]   tag
);
    // Field extraction for lookup and fetch addressing.
    always_comb begin
        fm_line = line[LINE_AW-1:SLOT_W];
        slot    = line[SLOT_W-1:0];
        idx     = fm_line[IDX_W-1:0];
        tag     = fm_line[FM_AW-1:IDX_W];
    end
endmodule

// File: rtl/fmr_cache.sv
// Fault-map cache: direct-mapped, CACHE_LINES lines, each holding a tag and
// ENTRIES entries. Lookup is combinational; a fill overwrites the indexed
// line on the clock edge. Valid bits are cleared by reset; data is not.
module fmr_cache #(
    parameter int ENTRIES     = 128,
    parameter int CACHE_LINES = 8,
    parameter int ENTRY_W     = 4,
    parameter int IDX_W       = 3,
    parameter int TAG_W       = 10,
    localparam int SLOT_W = $clog2(ENTRIES),
    localparam int DATA_W = ENTRIES * ENTRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [SLOT_W-1:0]  lk_slot,
    output logic               lk_hit,
    output logic [ENTRY_W-1:0] lk_entry,
    input  logic               fill_en,
    input  logic [DATA_W-1:0]  fill_data
);
    logic               vld_q [CACHE_LINES];
    logic [TAG_W-1:0]   tag_q [CACHE_LINES];
    logic [ENTRY_W-1:0] ent_q [CACHE_LINES][ENTRIES];
    logic [ENTRY_W-1:0] fill_ent [ENTRIES];

    // Unpack the returned fault-map line into per-slot entries.
    for (genvar s = 0; s < ENTRIES; s++) begin : g_unpack
        assign fill_ent[s] = fill_data[s*ENTRY_W +: ENTRY_W];
    end

    // Lookup: tag compare and entry select.
    always_comb begin
        lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_entry = ent_q[lk_idx][lk_slot];
    end

    // Valid and tag update; a fill validates the indexed line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < CACHE_LINES; l++) begin
                vld_q[l] <= 1'b0;
                tag_q[l] <= '0;
            end
        end else if (fill_en) begin
            vld_q[lk_idx] <= 1'b1;
            tag_q[lk_idx] <= lk_tag;
        end
    end

    // Entry storage write on fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int s = 0; s < ENTRIES; s++) begin
                ent_q[lk_idx][s] <= fill_ent[s];
            end
        end
    end
endmodule

// File: rtl/fmr_ctrl.sv
// Routing controller: accepts one request at a time, consults the cache for
// reads, fetches missing fault-map lines, issues one-cycle request pulses and
// tracks their completions. Assumes each done arrives after its request pulse.
module fmr_ctrl
    import fmr_pkg::*;
#(
    parameter int LINE_AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_rbit,
    input  logic [LINE_AW-1:0] req_line,
    output logic [LINE_AW-1:0] cur_line,
    input  logic               lk_hit,
    input  logic [ENTRY_W-1:0] lk_entry,
    output logic               fill_en,
    output logic               busy,
    output logic               mm_valid,
    output logic               mm_write,
    input  logic               mm_done,
    output logic               ra_valid,
    output logic               ra_write,
    output logic [WORD_W-1:0]  ra_word,
    input  logic               ra_done,
    output logic               fm_valid,
    input  logic               fm_done
);
    rt_state_e state_q;
    logic      cur_write_q, cur_rbit_q;
    logic      mm_pend_q, ra_pend_q;
    logic      mm_pend_n, ra_pend_n;

    // Outstanding flags after this cycle's completions.
    always_comb begin
        mm_pend_n = mm_pend_q && !mm_done;
        ra_pend_n = ra_pend_q && !ra_done;
        fill_en   = (state_q == ST_FILL) && fm_done;
        busy      = (state_q != ST_IDLE);
    end

    // Main sequencer: accept, look up, fetch, issue and wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_line    <= '0;
            cur_write_q <= 1'b0;
            cur_rbit_q  <= 1'b0;
            mm_valid    <= 1'b0;
            mm_write    <= 1'b0;
            ra_valid    <= 1'b0;
            ra_write    <= 1'b0;
            ra_word     <= '0;
            fm_valid    <= 1'b0;
            mm_pend_q   <= 1'b0;
            ra_pend_q   <= 1'b0;
        end else begin
            mm_valid <= 1'b0;
            ra_valid <= 1'b0;
            fm_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_line    <= req_line;
                        cur_write_q <= req_write;
                        cur_rbit_q  <= req_rbit;
                        state_q     <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (cur_write_q) begin
                        mm_valid  <= 1'b1;
                        mm_write  <= 1'b1;
                        mm_pend_q <= 1'b1;
                        ra_valid  <= cur_rbit_q;
                        ra_write  <= 1'b1;
                        ra_word   <= '0;
                        ra_pend_q <= cur_rbit_q;
                        state_q   <= ST_WAIT;
                    end else if (lk_hit) begin
                        mm_valid  <= 1'b1;
                        mm_write  <= 1'b0;
                        mm_pend_q <= 1'b1;
                        ra_valid  <= (lk_entry != '0);
                        ra_write  <= 1'b0;
                        ra_word   <= lk_entry[WORD_W-1:0];
                        ra_pend_q <= (lk_entry != '0);
                        state_q   <= ST_WAIT;
                    end else begin
                        fm_valid <= 1'b1;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fm_done) state_q <= ST_LOOK;
                end
                ST_WAIT: begin
                    mm_pend_q <= mm_pend_n;
                    ra_pend_q <= ra_pend_n;
                    if (!mm_pend_n && !ra_pend_n) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fmap_router.sv
// Top: fault-map guided request router. Wires the controller, the address
// splitter and the fault-map cache. Accepts a request only while not busy.
module fmap_router
    import fmr_pkg::*;
#(
    parameter int LINE_AW     = 20,
    parameter int ENTRIES     = 128,
    parameter int CACHE_LINES = 8,
    localparam int SLOT_W = $clog2(ENTRIES),
    localparam int FM_AW  = LINE_AW - SLOT_W,
    localparam int IDX_W  = $clog2(CACHE_LINES),
    localparam int TAG_W  = FM_AW - IDX_W,
    localparam int DATA_W = ENTRIES * ENTRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_rbit,
    input  logic [LINE_AW-1:0] req_line,
    output logic               busy,
    output logic               mm_valid,
    output logic               mm_write,
    output logic [LINE_AW-1:0] mm_line,
    input  logic               mm_done,
    output logic               ra_valid,
    output logic               ra_write,
    output logic [LINE_AW-1:0] ra_line,
    output logic [WORD_W-1:0]  ra_word,
    input  logic               ra_done,
    output logic               fm_valid,
    output logic [FM_AW-1:0]   fm_line,
    input  logic               fm_done,
    input  logic [DATA_W-1:0]  fm_data
);
    logic [LINE_AW-1:0] cur_line;
    logic [SLOT_W-1:0]  slot;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic               lk_hit, fill_en, busy_int;
    logic [ENTRY_W-1:0] lk_entry;

    fmr_addr_split #(
        .LINE_AW(LINE_AW), .ENTRIES(ENTRIES), .CACHE_LINES(CACHE_LINES)
    ) u_split (
        .line(cur_line), .fm_line(fm_line), .slot(slot), .idx(idx), .tag(tag)
    );

    fmr_cache #(
        .ENTRIES(ENTRIES), .CACHE_LINES(CACHE_LINES), .ENTRY_W(ENTRY_W),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(idx), .lk_tag(tag), .lk_slot(slot),
        .lk_hit(lk_hit), .lk_entry(lk_entry),
        .fill_en(fill_en), .fill_data(fm_data)
    );

    fmr_ctrl #(.LINE_AW(LINE_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && !busy_int), .req_write(req_write),
        .req_rbit(req_rbit), .req_line(req_line),
        .cur_line(cur_line), .lk_hit(lk_hit), .lk_entry(lk_entry),
        .fill_en(fill_en), .busy(busy_int),
        .mm_valid(mm_valid), .mm_write(mm_write), .mm_done(mm_done),
        .ra_valid(ra_valid), .ra_write(ra_write), .ra_word(ra_word),
        .ra_done(ra_done), .fm_valid(fm_valid), .fm_done(fm_done)
    );

    // Output address fan-out from the held request line.
    always_comb begin
        busy    = busy_int;
        mm_line = cur_line;
        ra_line = cur_line;
    end
endmodule

// File: rtl/fmap_router_chk.sv
// Checker: protocol and routing properties of fmap_router, bound to the top.
// Keeps its own copy of the last accepted request.
module fmap_router_chk #(
    parameter int LINE_AW = 20,
    parameter int FM_AW   = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_rbit,
    input logic [LINE_AW-1:0] req_line,
    input logic               busy,
    input logic               mm_valid,
    input logic               mm_write,
    input logic [LINE_AW-1:0] mm_line,
    input logic               ra_valid,
    input logic               ra_write,
    input logic [LINE_AW-1:0] ra_line,
    input logic               fm_valid,
    input logic [FM_AW-1:0]   fm_line
);
    logic [LINE_AW-1:0] acc_line;
    logic               acc_write, acc_rbit;

    // Capture each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_line  <= '0;
            acc_write <= 1'b0;
            acc_rbit  <= 1'b0;
        end else if (req_valid && !busy) begin
            acc_line  <= req_line;
            acc_write <= req_write;
            acc_rbit  <= req_rbit;
        end
    end

    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mm_valid || ra_valid || fm_valid));
    a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    a_r5_fetch_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fm_valid |-> (!mm_valid && !ra_valid));
    a_r4_ra_pairs_mm: assert property (@(posedge clk) disable iff (!rst_n)
        ra_valid |-> (mm_valid && (ra_write == mm_write) && (ra_line == mm_line)));
    a_r2_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fm_valid |-> (fm_line == acc_line[LINE_AW-1:LINE_AW-FM_AW]));
    a_r3_mm_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mm_valid |-> ((mm_line == acc_line) && (mm_write == acc_write)));
    a_r6_write_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fm_valid |-> !acc_write);
    a_r7_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_valid && mm_write && !acc_rbit) |-> !ra_valid);
endmodule

bind fmap_router fmap_router_chk #(.LINE_AW(LINE_AW), .FM_AW(FM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_rbit(req_rbit), .req_line(req_line), .busy(busy),
    .mm_valid(mm_valid), .mm_write(mm_write), .mm_line(mm_line),
    .ra_valid(ra_valid), .ra_write(ra_write), .ra_line(ra_line),
    .fm_valid(fm_valid), .fm_line(fm_line)
);

// File: tb/test_fmap_router.sv
// Scoreboard bench: driver task queues expected transactions, a monitor pops
// and compares them as request pulses appear, a responder returns completions.
module test_fmap_router;
    localparam int AW = 20;
    localparam int FW = 13;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_rbit = 1'b0;
    logic [AW-1:0] req_line = '0;
    logic          busy, mm_valid, mm_write, ra_valid, ra_write, fm_valid;
    logic [AW-1:0] mm_line, ra_line;
    logic [2:0]    ra_word;
    logic [FW-1:0] fm_line;
    logic          mm_done = 1'b0, ra_done = 1'b0, fm_done = 1'b0;
    logic [511:0]  fm_data = '0;

    fmap_router i_fmap_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_rbit(req_rbit), .req_line(req_line), .busy(busy),
        .mm_valid(mm_valid), .mm_write(mm_write), .mm_line(mm_line), .mm_done(mm_done),
        .ra_valid(ra_valid), .ra_write(ra_write), .ra_line(ra_line), .ra_word(ra_word),
        .ra_done(ra_done), .fm_valid(fm_valid), .fm_line(fm_line), .fm_done(fm_done),
        .fm_data(fm_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int            kind;   // 0 main, 1 replication, 2 fault-map fetch
        logic          wr;
        logic [AW-1:0] line;
        logic [2:0]    word;
    } item_t;

    item_t         exp_q[$];
    int            vectors = 0, errors = 0;
    string         cur_req = "R1";
    logic          bv[8];
    logic [FW-1:0] bt[8];

    // Bench fault model: every fifth line has a faulty word (low 3 bits).
    function automatic logic [3:0] entry_of(logic [AW-1:0] l);
        if (l % 5 == 0) return {1'b1, l[2:0]};
        return 4'h0;
    endfunction

    function automatic logic [511:0] fm_line_data(logic [FW-1:0] f);
        logic [511:0] d;
        for (int s = 0; s < 128; s++) d[s*4 +: 4] = entry_of({f, 7'(s)});
        return d;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    task automatic take(int kind, logic wr, logic [AW-1:0] line, logic [2:0] word);
        item_t e;
        vectors++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected kind=%0d wr=%0b line=%h word=%0d, expected none",
                     cur_req, kind, wr, line, word);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.wr != wr || e.line != line || e.word != word) begin
                errors++;
                $display("FAIL %s: got kind=%0d wr=%0b line=%h word=%0d, expected kind=%0d wr=%0b line=%h word=%0d",
                         cur_req, kind, wr, line, word, e.kind, e.wr, e.line, e.word);
            end
        end
    endtask

    // Monitor: compare each issued pulse against the scoreboard (R2..R7).
    initial forever begin
        @(negedge clk);
        if (mm_valid) take(0, mm_write, mm_line, 3'd0);
        if (ra_valid) take(1, ra_write, ra_line, ra_word);
        if (fm_valid) take(2, 1'b0, AW'(fm_line), 3'd0);
    end

    // Responder: completions a few cycles after each request pulse.
    initial begin
        int mt = 0, rt = 0, ft = 0;
        logic [FW-1:0] fl = '0;
        forever begin
            @(negedge clk);
            mm_done = 1'b0; ra_done = 1'b0; fm_done = 1'b0;
            if (mt > 0) begin mt--; if (mt == 0) mm_done = 1'b1; end
            if (rt > 0) begin rt--; if (rt == 0) ra_done = 1'b1; end
            if (ft > 0) begin
                ft--;
                if (ft == 0) begin fm_done = 1'b1; fm_data = fm_line_data(fl); end
            end
            if (mm_valid) mt = 2;
            if (ra_valid) rt = 3;
            if (fm_valid) begin ft = 2; fl = fm_line; end
        end
    end

    // Driver: queue expected transactions, present the request, wait idle.
    task automatic do_req(string tagr, logic wr, logic [AW-1:0] line, logic rb,
                          bit stray);
        item_t e;
        logic [FW-1:0] f;
        logic [3:0] en;
        cur_req = tagr;
        f = line[AW-1:7];
        if (wr) begin
            e = '{0, 1'b1, line, 3'd0}; exp_q.push_back(e);
            if (rb) begin e = '{1, 1'b1, line, 3'd0}; exp_q.push_back(e); end
        end else begin
            if (!(bv[f[2:0]] && bt[f[2:0]] == f)) begin
                e = '{2, 1'b0, AW'(f), 3'd0}; exp_q.push_back(e);
                bv[f[2:0]] = 1'b1; bt[f[2:0]] = f;
            end
            en = entry_of(line);
            e = '{0, 1'b0, line, 3'd0}; exp_q.push_back(e);
            if (en != 0) begin e = '{1, 1'b0, line, en[2:0]}; exp_q.push_back(e); end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_line = line; req_rbit = rb;
        @(negedge clk);
        if (stray) begin
            // R8: held request while busy must be ignored.
            req_write = ~wr; req_line = line ^ 20'h00F0F; req_rbit = 1'b1;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected transactions missing, expected 0",
                     tagr, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin bv[i] = 1'b0; bt[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;   // R1 reset state
        if (busy || mm_valid || ra_valid || fm_valid) begin
            errors++;
            $display("FAIL R1: busy/valids=%b%b%b%b, expected 0000",
                     busy, mm_valid, ra_valid, fm_valid);
        end
        do_req("R5", 1'b0, 20'h00005, 1'b0, 1'b0);  // miss, then dual read word 5
        do_req("R3", 1'b0, 20'h00006, 1'b0, 1'b0);  // hit, zero entry
        do_req("R4", 1'b0, 20'h0000A, 1'b0, 1'b0);  // hit, word 2
        do_req("R2", 1'b0, 20'h0007D, 1'b0, 1'b0);  // slot 125, word 5
        do_req("R2", 1'b0, 20'h0007F, 1'b0, 1'b0);  // last slot, zero
        do_req("R6", 1'b1, 20'h00007, 1'b1, 1'b0);  // dual write
        do_req("R7", 1'b1, 20'h00007, 1'b0, 1'b0);  // plain write
        do_req("R6", 1'b1, 20'h12345, 1'b1, 1'b0);  // uncached fm line, no fetch
        do_req("R9", 1'b0, 20'h00400, 1'b0, 1'b0);  // fm line 8 evicts index 0
        do_req("R9", 1'b0, 20'h00006, 1'b0, 1'b0);  // miss again after eviction
        do_req("R9", 1'b0, 20'h00080, 1'b0, 1'b0);  // fm line 1, index 1
        do_req("R9", 1'b0, 20'h00019, 1'b0, 1'b0);  // index 0 still fm line 0
        do_req("R9", 1'b0, 20'h000A5, 1'b0, 1'b0);  // index 1 still cached
        do_req("R8", 1'b0, 20'h00023, 1'b0, 1'b1);  // stray request during busy
        do_req("R8", 1'b1, 20'h00200, 1'b1, 1'b1);  // stray during write
        for (int i = 0; i < 24; i++) begin
            do_req("R5", i[0], AW'(i * 389 + 3), i[1], 1'b0);
        end
        summary();
    end
endmodule